// File: doc/BRIEF.md
# Radio Power-Mode Sequencer

This block decides which power mode a radio modem is in and drives the enables that go with each mode. While reset is low the modem is off and every output is parked low, pad drivers included. When reset is released, the oscillator warms up and the modem settles in Idle. From Idle, a mode command arriving over the serial control port puts the modem into one of two sleep depths. In the deeper sleep the oscillator is stopped and only the attention line can wake it. In the lighter sleep the oscillator keeps running, and either the attention line or an internal timer compare match can wake it. Each sleep depth has its own warm-up time before Idle is reached again.

A rising edge on the receive/transmit enable starts a receive or transmit burst, in the direction chosen by the latest select command. The receiver or transmitter enable comes on after a settling delay. A falling edge on the same input ends the burst at once. Every delay is a count of core clock cycles taken from a parameter. The lighter sleep adds one period of the selected clock-out frequency to its wake time; the default parameters assume a 16 MHz core clock.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, `osc_en_o`, `spi_en_o`, `clko_en_o`, `pad_oe_o`, `rx_en_o`, `tx_en_o`, `out_of_idle_o` and `cmd_err_o` are all low.
- R2: After `rst_n` rises, Idle is reached on the (1+PWRUP_CYC)-th rising clock edge. Idle drives `osc_en_o`, `spi_en_o`, `clko_en_o` and `pad_oe_o` high.
- R3: Command codes are 1 hibernate, 2 doze, 3 select receive and 4 select transmit; any other code has no effect. A command with `cmd_valid_i` high is acted on only in Idle. In every other state it changes nothing and sets `cmd_err_o`, which stays high until reset.
- R4: Hibernate drives `osc_en_o`, `spi_en_o` and `clko_en_o` low and `pad_oe_o` high. Only `attn_i` wakes it, and Idle follows 1+HIB_WAKE_CYC edges after the attention input is seen. A timer match has no effect.
- R5: Doze drives `osc_en_o` and `pad_oe_o` high and `spi_en_o` low. `attn_i` or `timer_match_i` wakes it, and Idle follows 1+DOZE_WAKE_CYC+P edges later. P is 1, 2, 4, 8, 16, 256, 488 or 976 for `clko_sel_i` = 0 to 7.
- R6: In Doze, `clko_en_o` equals `clko_doze_en_i` AND (`clko_sel_i` >= 4), so clock-out runs only at 1 MHz or below. During the wake-up warm-up it is low.
- R7: A rising edge of `trx_en_i` in Idle starts a burst. The direction is set by the latest select command; a select in the same cycle counts, and after reset the direction is receive. The burst raises `rx_en_o` or `tx_en_o`, never both, 1+TRX_SETTLE_CYC edges after the edge. A sleep command in the same cycle takes precedence and the edge is dropped.
- R8: A falling edge of `trx_en_i` during settling or an active burst returns the block to Idle on the next clock edge, with `rx_en_o` and `tx_en_o` low.
- R9: `out_of_idle_o` is high exactly while a burst is settling or active.
- R10: Wake events that arrive during any warm-up (power-up, hibernate wake, doze wake) are ignored, and the warm-up length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset; holds the block off |
| attn_i | input | 1 | Attention wake request, level sensitive |
| trx_en_i | input | 1 | Receive/transmit enable; edges start and stop a burst |
| cmd_valid_i | input | 1 | A mode command is present this cycle |
| cmd_code_i | input | 3 | Mode command code |
| timer_match_i | input | 1 | Internal wake timer compare match |
| clko_doze_en_i | input | 1 | Allows clock-out while dozing |
| clko_sel_i | input | 3 | Clock-out frequency select, 0 fastest to 7 slowest |
| osc_en_o | output | 1 | Oscillator enable |
| spi_en_o | output | 1 | Serial control port enable |
| clko_en_o | output | 1 | Clock-out enable |
| pad_oe_o | output | 1 | Digital output drive enable; low means tri-stated |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| out_of_idle_o | output | 1 | High while a burst is settling or active |
| cmd_err_o | output | 1 | Sticky flag for a command refused outside Idle |

## Verification
A wrong mode register shows up at the enables on the next clock edge. The clearest signs are the oscillator or serial-port enable in the wrong level, or `out_of_idle_o` disagreeing with the radio enables. A warm-up counter that restarts or runs off by one does not show until later: only the edge on which `spi_en_o`, `rx_en_o` or `tx_en_o` rises moves, so every wake path is timed edge by edge from its stimulus. A fault in command filtering can stay hidden until the next command. That is why each refused command is followed at once by a check of both the sticky flag and the unchanged enables.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [3:0] {
    PM_OFF   = 4'd0,
    PM_PWRUP = 4'd1,
    PM_IDLE  = 4'd2,
    PM_HIB   = 4'd3,
    PM_HWAKE = 4'd4,
    PM_DOZE  = 4'd5,
    PM_DWAKE = 4'd6,
    PM_RXSET = 4'd7,
    PM_RX    = 4'd8,
    PM_TXSET = 4'd9,
    PM_TX    = 4'd10
  } pm_state_e;

  localparam int CMD_W  = 3;
  localparam int CSEL_W = 3;

  localparam logic [CMD_W-1:0] PM_CMD_HIB  = 3'd1;
  localparam logic [CMD_W-1:0] PM_CMD_DOZE = 3'd2;
  localparam logic [CMD_W-1:0] PM_CMD_RX   = 3'd3;
  localparam logic [CMD_W-1:0] PM_CMD_TX   = 3'd4;

  // slowest clock-out period in core clocks, bounds the doze wake delay
  localparam int unsigned CLKO_MAX_PERIOD = 976;

  typedef struct packed {
    logic osc;
    logic spi;
    logic clko;
    logic oe;
    logic rx;
    logic tx;
    logic ooi;
  } pm_drive_t;

  // clock-out period in core clocks (16 MHz core): divide by 2^sel up to 1 MHz,
  // then the three low-rate settings
  function automatic int unsigned clko_period_cyc(input logic [CSEL_W-1:0] sel);
    case (sel)
      3'd5:    return 256;
      3'd6:    return 488;
      3'd7:    return CLKO_MAX_PERIOD;
      default: return 32'd1 << sel;
    endcase
  endfunction

  // true when the selected clock-out rate is 1 MHz or slower
  function automatic logic clko_slow(input logic [CSEL_W-1:0] sel);
    return sel >= 3'd4;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pms_edge_det.sv
module pms_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
  assign fall_o = ~level_i & level_q;

endmodule

// File: rtl/pms_warm_timer.sv
module pms_warm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  // counts cycles spent in the current state; saturates so it never wraps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != {CW{1'b1}}) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == limit_i - CW'(1));

endmodule

// File: rtl/pms_out_dec.sv
module pms_out_dec
  import pwr_mode_pkg::*;
(
  input  pm_state_e                state_i,
  input  logic                     clko_doze_en_i,
  input  logic [CSEL_W-1:0]        clko_sel_i,
  output pm_drive_t                drv_o
);

  always_comb begin
    drv_o = '0;
    case (state_i)
      PM_OFF:   drv_o = '0;
      PM_PWRUP, PM_HWAKE, PM_DWAKE: begin
        drv_o.osc = 1'b1;
        drv_o.oe  = 1'b1;
      end
      PM_IDLE: begin
        drv_o.osc  = 1'b1;
        drv_o.spi  = 1'b1;
        drv_o.clko = 1'b1;
        drv_o.oe   = 1'b1;
      end
      PM_HIB: drv_o.oe = 1'b1;
      PM_DOZE: begin
        drv_o.osc  = 1'b1;
        drv_o.oe   = 1'b1;
        drv_o.clko = clko_doze_en_i & clko_slow(clko_sel_i);
      end
      PM_RXSET, PM_RX, PM_TXSET, PM_TX: begin
        drv_o.osc  = 1'b1;
        drv_o.spi  = 1'b1;
        drv_o.clko = 1'b1;
        drv_o.oe   = 1'b1;
        drv_o.ooi  = 1'b1;
        drv_o.rx   = (state_i == PM_RX);
        drv_o.tx   = (state_i == PM_TX);
      end
      default: drv_o = '0;
    endcase
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned PWRUP_CYC      = 240000,
  parameter int unsigned HIB_WAKE_CYC   = 160000,
  parameter int unsigned DOZE_WAKE_CYC  = 4800,
  parameter int unsigned TRX_SETTLE_CYC = 2304
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       attn_i,
  input  logic       trx_en_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_code_i,
  input  logic       timer_match_i,
  input  logic       clko_doze_en_i,
  input  logic [2:0] clko_sel_i,
  output logic       osc_en_o,
  output logic       spi_en_o,
  output logic       clko_en_o,
  output logic       pad_oe_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       out_of_idle_o,
  output logic       cmd_err_o
);

  localparam int unsigned MAX_LIM = max2(max2(PWRUP_CYC, HIB_WAKE_CYC),
                                         max2(DOZE_WAKE_CYC + CLKO_MAX_PERIOD, TRX_SETTLE_CYC));
  localparam int CW = $clog2(MAX_LIM + 1);

  pm_state_e     state_q, state_d;
  logic          dir_q, dir_d;      // 0 receive, 1 transmit
  logic          err_q;
  logic          trx_rise, trx_fall;
  logic          tmr_done, tmr_restart;
  logic [CW-1:0] tmr_limit;
  logic          in_warm;
  logic          cmd_refused;
  logic          cmd_hib, cmd_doze, cmd_rx, cmd_tx;
  pm_drive_t     drv;

  pms_edge_det u_trx_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (trx_en_i),
    .rise_o  (trx_rise),
    .fall_o  (trx_fall)
  );

  always_comb begin
    case (state_q)
      PM_PWRUP:          tmr_limit = CW'(PWRUP_CYC);
      PM_HWAKE:          tmr_limit = CW'(HIB_WAKE_CYC);
      PM_DWAKE:          tmr_limit = CW'(DOZE_WAKE_CYC + clko_period_cyc(clko_sel_i));
      PM_RXSET, PM_TXSET: tmr_limit = CW'(TRX_SETTLE_CYC);
      default:           tmr_limit = CW'(1);
    endcase
  end

  assign tmr_restart = (state_d != state_q);

  pms_warm_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .limit_i   (tmr_limit),
    .done_o    (tmr_done)
  );

  assign cmd_hib  = cmd_valid_i && (cmd_code_i == PM_CMD_HIB);
  assign cmd_doze = cmd_valid_i && (cmd_code_i == PM_CMD_DOZE);
  assign cmd_rx   = cmd_valid_i && (cmd_code_i == PM_CMD_RX);
  assign cmd_tx   = cmd_valid_i && (cmd_code_i == PM_CMD_TX);
  assign cmd_refused = cmd_valid_i && (state_q != PM_IDLE);
  assign in_warm  = (state_q == PM_PWRUP) || (state_q == PM_HWAKE) || (state_q == PM_DWAKE);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    case (state_q)
      PM_OFF:   state_d = PM_PWRUP;
      PM_PWRUP: if (tmr_done) state_d = PM_IDLE;
      PM_IDLE: begin
        if (cmd_rx)      dir_d = 1'b0;
        else if (cmd_tx) dir_d = 1'b1;
        if (cmd_hib)       state_d = PM_HIB;
        else if (cmd_doze) state_d = PM_DOZE;
        else if (trx_rise) state_d = dir_d ? PM_TXSET : PM_RXSET;
      end
      PM_HIB:   if (attn_i) state_d = PM_HWAKE;
      PM_HWAKE: if (tmr_done) state_d = PM_IDLE;
      PM_DOZE:  if (attn_i || timer_match_i) state_d = PM_DWAKE;
      PM_DWAKE: if (tmr_done) state_d = PM_IDLE;
      PM_RXSET: begin
        if (trx_fall)      state_d = PM_IDLE;
        else if (tmr_done) state_d = PM_RX;
      end
      PM_TXSET: begin
        if (trx_fall)      state_d = PM_IDLE;
        else if (tmr_done) state_d = PM_TX;
      end
      PM_RX, PM_TX: if (trx_fall) state_d = PM_IDLE;
      default:  state_d = PM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_OFF;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      if (cmd_refused) err_q <= 1'b1;
    end
  end

  pms_out_dec u_dec (
    .state_i        (state_q),
    .clko_doze_en_i (clko_doze_en_i),
    .clko_sel_i     (clko_sel_i),
    .drv_o          (drv)
  );

  assign osc_en_o      = drv.osc;
  assign spi_en_o      = drv.spi;
  assign clko_en_o     = drv.clko;
  assign pad_oe_o      = drv.oe;
  assign rx_en_o       = drv.rx;
  assign tx_en_o       = drv.tx;
  assign out_of_idle_o = drv.ooi;
  assign cmd_err_o     = err_q;

  // ---------------- assertions ----------------
  p_offquiet_r1: assert property (@(posedge clk)
    !rst_n |-> !(osc_en_o || spi_en_o || clko_en_o || pad_oe_o || rx_en_o || tx_en_o || cmd_err_o));

  p_spiosc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en_o |-> osc_en_o);

  p_errsticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_o |=> cmd_err_o);

  p_errset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refused |=> cmd_err_o);

  p_sleepentry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PM_HIB || state_q == PM_DOZE) && $past(state_q) != state_q)
      |-> $past(state_q) == PM_IDLE);

  p_hibhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_HIB && !attn_i) |=> state_q == PM_HIB);

  p_dozewake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DOZE && (attn_i || timer_match_i)) |=> state_q == PM_DWAKE);

  p_onedir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en_o && tx_en_o));

  p_fallidle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trx_fall && out_of_idle_o) |=> state_q == PM_IDLE);

  p_ooi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_o || tx_en_o) |-> out_of_idle_o);

  p_warmhold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_warm && !tmr_done) |=> state_q == $past(state_q));

endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;

  localparam int PW = 20;
  localparam int HW = 15;
  localparam int DW = 6;
  localparam int TS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic attn_i = 1'b0, trx_en_i = 1'b0, cmd_valid_i = 1'b0, timer_match_i = 1'b0;
  logic [2:0] cmd_code_i = 3'd0;
  logic clko_doze_en_i = 1'b0;
  logic [2:0] clko_sel_i = 3'd0;
  logic osc_en_o, spi_en_o, clko_en_o, pad_oe_o, rx_en_o, tx_en_o, out_of_idle_o, cmd_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_mark = 0;
  int exp_lat[$];
  string exp_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_mode_seq #(
    .PWRUP_CYC(PW), .HIB_WAKE_CYC(HW), .DOZE_WAKE_CYC(DW), .TRX_SETTLE_CYC(TS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .attn_i(attn_i), .trx_en_i(trx_en_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .timer_match_i(timer_match_i),
    .clko_doze_en_i(clko_doze_en_i), .clko_sel_i(clko_sel_i),
    .osc_en_o(osc_en_o), .spi_en_o(spi_en_o), .clko_en_o(clko_en_o), .pad_oe_o(pad_oe_o),
    .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .out_of_idle_o(out_of_idle_o), .cmd_err_o(cmd_err_o)
  );

  function automatic int period(input int sel);
    int p[8] = '{1, 2, 4, 8, 16, 256, 488, 976};
    return p[sel];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected latency to the next ready edge
  task automatic expect_lat(input string tag, input int lat);
    exp_lat.push_back(lat);
    exp_tag.push_back(tag);
    t_mark = cyc;
  endtask

  task automatic drain();
    int w = 0;
    while (exp_lat.size() != 0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (exp_lat.size() != 0) begin
      chk(exp_tag[0], "ready edge never came", 0, 1);
      exp_lat.delete();
      exp_tag.delete();
    end
  endtask

  task automatic send_cmd(input logic [2:0] code);
    cmd_valid_i = 1'b1;
    cmd_code_i  = code;
    tick(1);
    cmd_valid_i = 1'b0;
  endtask

  // monitor side: every rising ready edge pops and compares one expected latency
  logic spi_p = 1'b0, rx_p = 1'b0, tx_p = 1'b0;
  always @(negedge clk) begin
    if ((spi_en_o && !spi_p) || (rx_en_o && !rx_p) || (tx_en_o && !tx_p)) begin
      if (exp_lat.size() == 0) begin
        chk("R7/R8", "unexpected ready edge", 1, 0);
      end else begin
        chk(exp_tag[0], "ready latency", cyc - t_mark, exp_lat[0]);
        void'(exp_lat.pop_front());
        void'(exp_tag.pop_front());
      end
    end
    spi_p = spi_en_o;
    rx_p  = rx_en_o;
    tx_p  = tx_en_o;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    // R1: all quiet in reset
    chk("R1", "outputs in reset",
        {osc_en_o, spi_en_o, clko_en_o, pad_oe_o, rx_en_o, tx_en_o, out_of_idle_o, cmd_err_o}, 0);

    // R2: power-up
    rst_n = 1'b1;
    expect_lat("R2", 1 + PW);
    drain();
    chk("R2", "idle enables", {osc_en_o, spi_en_o, clko_en_o, pad_oe_o}, 4'hF);
    chk("R9", "ooi in idle", out_of_idle_o, 0);

    // R4: hibernate
    send_cmd(3'd1);
    chk("R4", "hibernate enables", {osc_en_o, spi_en_o, clko_en_o, pad_oe_o}, 4'b0001);
    timer_match_i = 1'b1; tick(1); timer_match_i = 1'b0; tick(4);
    chk("R4", "timer ignored in hibernate", osc_en_o, 0);
    send_cmd(3'd2);
    chk("R3", "err after refused command", cmd_err_o, 1);
    chk("R3", "refused command leaves osc off", osc_en_o, 0);
    attn_i = 1'b1;
    expect_lat("R4/R10", 1 + HW);
    tick(1); attn_i = 1'b0; tick(5);
    attn_i = 1'b1; tick(1); attn_i = 1'b0;   // R10: extra wake during warm-up
    drain();
    chk("R3", "err stays set", cmd_err_o, 1);

    // R5/R6: doze
    clko_doze_en_i = 1'b1; clko_sel_i = 3'd4;
    send_cmd(3'd2);
    chk("R5", "doze enables osc/spi/oe", {osc_en_o, spi_en_o, pad_oe_o}, 3'b101);
    chk("R6", "clko at 1 MHz", clko_en_o, 1);
    clko_sel_i = 3'd3; tick(1);
    chk("R6", "clko off at 2 MHz", clko_en_o, 0);
    clko_sel_i = 3'd4; clko_doze_en_i = 1'b0; tick(1);
    chk("R6", "clko off when config clear", clko_en_o, 0);
    clko_doze_en_i = 1'b1; tick(1);
    timer_match_i = 1'b1;
    expect_lat("R5", 1 + DW + period(4));
    tick(1); timer_match_i = 1'b0;
    chk("R6", "clko off in doze wake", clko_en_o, 0);
    drain();
    clko_sel_i = 3'd7;
    send_cmd(3'd2);
    tick(2);
    chk("R6", "clko at slowest rate", clko_en_o, 1);
    attn_i = 1'b1;
    expect_lat("R5", 1 + DW + period(7));
    tick(1); attn_i = 1'b0;
    drain();
    clko_sel_i = 3'd0;

    // R7/R8/R9: receive burst
    send_cmd(3'd3);
    trx_en_i = 1'b1;
    expect_lat("R7", 1 + TS);
    tick(1);
    chk("R9", "ooi during settle", out_of_idle_o, 1);
    chk("R7", "rx not yet enabled", rx_en_o, 0);
    drain();
    chk("R7", "rx only", {rx_en_o, tx_en_o}, 2'b10);
    chk("R9", "ooi while active", out_of_idle_o, 1);
    trx_en_i = 1'b0; tick(1);
    chk("R8", "fall ends burst", {rx_en_o, out_of_idle_o}, 0);
    chk("R8", "back in idle", spi_en_o, 1);

    // R7: transmit select in the same cycle as the edge
    cmd_valid_i = 1'b1; cmd_code_i = 3'd4; trx_en_i = 1'b1;
    expect_lat("R7", 1 + TS);
    tick(1); cmd_valid_i = 1'b0;
    drain();
    chk("R7", "tx only", {rx_en_o, tx_en_o}, 2'b01);
    trx_en_i = 1'b0; tick(1);
    chk("R8", "tx dropped", tx_en_o, 0);

    // R8: fall during settling
    send_cmd(3'd3);
    trx_en_i = 1'b1; tick(3); trx_en_i = 1'b0; tick(1);
    chk("R8", "ooi off after early fall", out_of_idle_o, 0);
    tick(12);
    chk("R8", "rx never enabled", rx_en_o, 0);

    // R1 again, then R10 during power-up
    rst_n = 1'b0; tick(2);
    chk("R1", "outputs in second reset",
        {osc_en_o, spi_en_o, clko_en_o, pad_oe_o, rx_en_o, tx_en_o, out_of_idle_o, cmd_err_o}, 0);
    rst_n = 1'b1;
    expect_lat("R2/R10", 1 + PW);
    tick(4); attn_i = 1'b1; timer_match_i = 1'b1;
    tick(1); attn_i = 1'b0; timer_match_i = 1'b0;
    drain();

    // R3: command during an active burst
    send_cmd(3'd3);
    trx_en_i = 1'b1;
    expect_lat("R7", 1 + TS);
    drain();
    send_cmd(3'd1);
    chk("R3", "err from command in burst", cmd_err_o, 1);
    chk("R3", "burst unaffected", {rx_en_o, osc_en_o}, 2'b11);
    trx_en_i = 1'b0; tick(1);

    // R7: sleep command beats a same-cycle edge
    cmd_valid_i = 1'b1; cmd_code_i = 3'd1; trx_en_i = 1'b1;
    tick(1); cmd_valid_i = 1'b0;
    chk("R7", "sleep wins over edge", {osc_en_o, out_of_idle_o}, 0);
    tick(10);
    chk("R7", "dropped edge starts nothing", rx_en_o, 0);
    trx_en_i = 1'b0;
    attn_i = 1'b1;
    expect_lat("R4", 1 + HW);
    tick(1); attn_i = 1'b0;
    drain();
    chk("R7", "no burst after wake", out_of_idle_o, 0);

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule